// File: doc/BRIEF.md
# Miss Tracking Queue

This block keeps track of cache misses that are still outstanding. It has a small pool of entries. Each live entry records a block address, a secure-space bit, the earliest time at which it may be sent, an order tag stamped at allocation, a flag that says whether a reply is expected, and an in-service flag. A ready list holds the indices of entries that are waiting to be sent, in the order they will go. The head of that list is offered for issue once the current time reaches its ready time.

The cache controller sends one command per cycle. The commands are:
- allocate an entry;
- release an entry;
- mark an entry as sent;
- put a sent entry back in line for a resend;
- promote a waiting entry to the head of the list.

Before it allocates, the controller can check for an existing entry for the same block with a combinational lookup. Two status flags guide allocation. A full flag keeps a reserve of entries free for operations that need several entries at once. A can-prefetch flag keeps a further reserve back for demand misses.

Top module: `miss_track_queue`

## Requirements
- R1: The pool has REQ_ENTRIES + RESERVE − 1 physical entries (5 by default). An allocation takes the lowest-numbered free entry, which `allocIdx` shows ahead of time. An allocation while all physical entries are live changes no state.
- R2: `isFull` is 1 exactly when `allocCount` is greater than the entry count minus RESERVE (count ≥ 4 by default).
- R3: `canPrefetch` is 1 exactly when `allocCount` is less than the entry count minus (RESERVE + DEMAND_RESERVE) (count ≤ 1 by default).
- R4: A lookup hits only a live entry whose address and secure bit both equal the query. `lkIdx` gives the lowest-numbered such entry. `lkHit` is 0 when there is no such entry.
- R5: `issueValid` is 1 only when the ready list is non-empty and the ready time of its head is at most `curTime`. `issueIdx` is then that head.
- R6: `nextReady` gives the ready time of the head of the ready list, or all ones when the list is empty.
- R7: Mark-in-service on a live, waiting entry takes it off the ready list. If the entry expects a reply, it becomes in service and `inServiceCount` rises by one. If it expects no reply, it is released instead.
- R8: Mark-pending on an in-service entry clears its in-service state, lowers `inServiceCount`, and appends the entry at the tail of the ready list.
- R9: Move-to-front puts a waiting entry at the head of the ready list and keeps the order of the others. It has no effect on an in-service entry.
- R10: An allocated entry is appended at the tail of the ready list. Its order tag is one more than the tag of the previous allocation since reset, starting at 0. A release frees the entry and takes it off the ready list if it is there.
- R11: `errFlag` becomes 1 on an allocation while no entry is free, or on a release of a free entry. It stays 1 until reset.
- R12: Only one command acts per cycle. The priority is allocate, then release, then in-service, then pending, then front.
- R13: After reset, no entry is live, both counts are 0, `issueValid` is 0, `nextReady` is all ones and `errFlag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| curTime | input | TIME_W | Current time, compared with entry ready times |
| cmdAlloc | input | 1 | Allocate command |
| cmdFree | input | 1 | Release entry `cmdIdx` |
| cmdInSvc | input | 1 | Mark entry `cmdIdx` as sent |
| cmdPending | input | 1 | Return entry `cmdIdx` to the ready list |
| cmdFront | input | 1 | Move entry `cmdIdx` to the head of the ready list |
| cmdIdx | input | IDX_W | Entry addressed by the non-allocate commands |
| allocAddr | input | ADDR_W | Block address for allocation |
| allocSecure | input | 1 | Secure-space bit for allocation |
| allocReady | input | TIME_W | Ready time for allocation |
| allocNeedResp | input | 1 | Allocated entry expects a reply |
| lkAddr | input | ADDR_W | Lookup address |
| lkSecure | input | 1 | Lookup secure bit |
| lkHit | output | 1 | Lookup found a live match |
| lkIdx | output | IDX_W | Lowest matching entry |
| allocIdx | output | IDX_W | Entry the next allocation will take |
| issueValid | output | 1 | Head of the ready list may be sent |
| issueIdx | output | IDX_W | Head entry of the ready list |
| issueOrder | output | ORD_W | Order tag of the head entry |
| nextReady | output | TIME_W | Ready time of the head, or all ones |
| allocCount | output | CNT_W | Number of live entries |
| inServiceCount | output | CNT_W | Number of in-service entries |
| isFull | output | 1 | Reserve threshold reached |
| canPrefetch | output | 1 | A prefetch may allocate |
| errFlag | output | 1 | Sticky misuse indicator |

## Verification
Commands are registered on the clock edge. The counts, the flags, the issue outputs and `nextReady` all change on the first edge after a command is driven. The driver applies each command at a falling edge and queues the state expected after the next rising edge. The monitor compares that state 1 ns after the rising edge, so every check falls within the single cycle in which the result becomes due. Lookups and `allocIdx` are combinational in the current state, so they are checked in the same half cycle, with no command pending.

// File: rtl/mtq_pkg.sv
package mtq_pkg;
  typedef struct packed {
    logic doAlloc;
    logic doFree;
    logic doInSvc;
    logic doPending;
    logic doFront;
  } mtqStrobe_t;
endpackage

// File: rtl/mtq_ctrl.sv
module mtq_ctrl
  import mtq_pkg::*;
#(
  parameter int NUM     = 5,
  parameter int RESERVE = 2,
  parameter int DEMAND  = 1,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdAlloc,
  input  logic             cmdFree,
  input  logic             cmdInSvc,
  input  logic             cmdPending,
  input  logic             cmdFront,
  input  logic [IDX_W-1:0] cmdIdx,
  input  logic [NUM-1:0]   validVec,
  input  logic [NUM-1:0]   inSvcVec,
  input  logic [NUM-1:0]   respVec,
  input  logic [IDX_W-1:0] freeIdx,
  input  logic             freeAvail,
  output mtqStrobe_t       strb,
  output logic [IDX_W-1:0] opIdx,
  output logic [CNT_W-1:0] allocCnt,
  output logic [CNT_W-1:0] svcCnt,
  output logic             isFull,
  output logic             canPrefetch,
  output logic             errFlag
);
  localparam int FULL_LIM = NUM - RESERVE;
  localparam int PF_LIM   = NUM - RESERVE - DEMAND;

  logic idxOk, selValid, selSvc, selResp, errNow;
  logic [CNT_W-1:0] allocNext, svcNext;

  assign idxOk    = int'(cmdIdx) < NUM;
  assign selValid = idxOk && validVec[cmdIdx];
  assign selSvc   = idxOk && inSvcVec[cmdIdx];
  assign selResp  = idxOk && respVec[cmdIdx];

  // priority decode, one command per cycle
  always_comb begin
    strb   = '0;
    errNow = 1'b0;
    opIdx  = cmdIdx;
    if (cmdAlloc) begin
      opIdx = freeIdx;
      if (freeAvail) strb.doAlloc = 1'b1;
      else           errNow       = 1'b1;
    end else if (cmdFree) begin
      if (selValid) strb.doFree = 1'b1;
      else          errNow      = 1'b1;
    end else if (cmdInSvc) begin
      strb.doInSvc = selValid && !selSvc;
    end else if (cmdPending) begin
      strb.doPending = selValid && selSvc;
    end else if (cmdFront) begin
      strb.doFront = selValid && !selSvc;
    end
  end

  always_comb begin
    allocNext = allocCnt;
    svcNext   = svcCnt;
    if (strb.doAlloc) allocNext = allocCnt + CNT_W'(1);
    if (strb.doFree) begin
      allocNext = allocCnt - CNT_W'(1);
      if (selSvc) svcNext = svcCnt - CNT_W'(1);
    end
    if (strb.doInSvc) begin
      if (selResp) svcNext   = svcCnt + CNT_W'(1);
      else         allocNext = allocCnt - CNT_W'(1);
    end
    if (strb.doPending) svcNext = svcCnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      allocCnt <= '0;
      svcCnt   <= '0;
      errFlag  <= 1'b0;
    end else begin
      allocCnt <= allocNext;
      svcCnt   <= svcNext;
      if (errNow) errFlag <= 1'b1;
    end
  end

  assign isFull      = int'(allocCnt) > FULL_LIM;
  assign canPrefetch = (PF_LIM > 0) && (int'(allocCnt) < PF_LIM);

  // R1
  count_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(allocCnt) == $countones(validVec));
  // R7
  svc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(svcCnt) == $countones(inSvcVec & validVec));
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  // R2
  full_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    isFull |-> !canPrefetch);
endmodule

// File: rtl/mtq_store.sv
module mtq_store
  import mtq_pkg::*;
#(
  parameter int NUM    = 5,
  parameter int ADDR_W = 16,
  parameter int TIME_W = 16,
  parameter int ORD_W  = 8,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  mtqStrobe_t        strb,
  input  logic [IDX_W-1:0]  opIdx,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic              allocSecure,
  input  logic [TIME_W-1:0] allocReady,
  input  logic              allocNeedResp,
  input  logic [TIME_W-1:0] curTime,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkSecure,
  output logic [NUM-1:0]    validVec,
  output logic [NUM-1:0]    inSvcVec,
  output logic [NUM-1:0]    respVec,
  output logic [IDX_W-1:0]  freeIdx,
  output logic              freeAvail,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIdx,
  output logic              issueValid,
  output logic [IDX_W-1:0]  issueIdx,
  output logic [ORD_W-1:0]  issueOrder,
  output logic [TIME_W-1:0] nextReady
);
  logic [ADDR_W-1:0] addrQ  [NUM];
  logic              secQ   [NUM];
  logic [TIME_W-1:0] readyQ [NUM];
  logic [ORD_W-1:0]  orderQ [NUM];
  logic [ORD_W-1:0]  orderCtr;

  logic [IDX_W-1:0]  rl  [NUM];
  logic [IDX_W-1:0]  rlN [NUM];
  logic [CNT_W-1:0]  rlCnt, rlCntN;
  logic              posHit;
  logic [IDX_W-1:0]  pos;

  // lowest free entry and lowest lookup match
  always_comb begin
    freeIdx = '0;
    lkHit   = 1'b0;
    lkIdx   = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = IDX_W'(i);
      if (validVec[i] && addrQ[i] == lkAddr && secQ[i] == lkSecure) begin
        lkHit = 1'b1;
        lkIdx = IDX_W'(i);
      end
    end
  end
  assign freeAvail = ~&validVec;

  // position of the addressed entry in the ready list
  always_comb begin
    posHit = 1'b0;
    pos    = '0;
    for (int p = NUM - 1; p >= 0; p--) begin
      if (p < int'(rlCnt) && rl[p] == opIdx) begin
        posHit = 1'b1;
        pos    = IDX_W'(p);
      end
    end
  end

  // ready list update
  always_comb begin
    for (int p = 0; p < NUM; p++) rlN[p] = rl[p];
    rlCntN = rlCnt;
    if ((strb.doAlloc || strb.doPending) && int'(rlCnt) < NUM) begin
      rlN[rlCnt] = opIdx;
      rlCntN     = rlCnt + CNT_W'(1);
    end
    if ((strb.doInSvc || strb.doFree) && posHit) begin
      for (int p = 0; p < NUM - 1; p++)
        if (p >= int'(pos)) rlN[p] = rl[p+1];
      rlCntN = rlCnt - CNT_W'(1);
    end
    if (strb.doFront && posHit) begin
      for (int p = 1; p < NUM; p++)
        if (p <= int'(pos)) rlN[p] = rl[p-1];
      rlN[0] = opIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rlCnt <= '0;
      for (int p = 0; p < NUM; p++) rl[p] <= '0;
    end else begin
      rlCnt <= rlCntN;
      for (int p = 0; p < NUM; p++) rl[p] <= rlN[p];
    end
  end

  // entry state
  generate
    for (genvar e = 0; e < NUM; e++) begin : gEntry
      logic hitMe;
      assign hitMe = (opIdx == IDX_W'(e));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          validVec[e] <= 1'b0;
          inSvcVec[e] <= 1'b0;
          respVec[e]  <= 1'b0;
          addrQ[e]    <= '0;
          secQ[e]     <= 1'b0;
          readyQ[e]   <= '0;
          orderQ[e]   <= '0;
        end else if (hitMe) begin
          if (strb.doAlloc) begin
            validVec[e] <= 1'b1;
            inSvcVec[e] <= 1'b0;
            respVec[e]  <= allocNeedResp;
            addrQ[e]    <= allocAddr;
            secQ[e]     <= allocSecure;
            readyQ[e]   <= allocReady;
            orderQ[e]   <= orderCtr;
          end
          if (strb.doFree) begin
            validVec[e] <= 1'b0;
            inSvcVec[e] <= 1'b0;
          end
          if (strb.doInSvc) begin
            if (respVec[e]) inSvcVec[e] <= 1'b1;
            else            validVec[e] <= 1'b0;
          end
          if (strb.doPending) inSvcVec[e] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             orderCtr <= '0;
    else if (strb.doAlloc) orderCtr <= orderCtr + ORD_W'(1);
  end

  // head of the ready list
  assign issueIdx   = rl[0];
  assign issueOrder = orderQ[rl[0]];
  assign issueValid = (rlCnt != '0) && (readyQ[rl[0]] <= curTime);
  assign nextReady  = (rlCnt == '0) ? '1 : readyQ[rl[0]];

  // R10
  alloc_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doAlloc |=> validVec[$past(opIdx)] && !inSvcVec[$past(opIdx)]);
  // R7
  insvc_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doInSvc && respVec[opIdx]) |=> inSvcVec[$past(opIdx)]);
  // R10
  free_dead_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doFree |=> !validVec[$past(opIdx)]);
  // R9
  front_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doFront |=> rl[0] == $past(opIdx));
endmodule

// File: rtl/miss_track_queue.sv
module miss_track_queue
  import mtq_pkg::*;
#(
  parameter int REQ_ENTRIES    = 4,
  parameter int RESERVE        = 2,
  parameter int DEMAND_RESERVE = 1,
  parameter int ADDR_W         = 16,
  parameter int TIME_W         = 16,
  parameter int ORD_W          = 8,
  localparam int NUM   = REQ_ENTRIES + RESERVE - 1,
  localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1,
  localparam int CNT_W = $clog2(NUM + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] curTime,
  input  logic              cmdAlloc,
  input  logic              cmdFree,
  input  logic              cmdInSvc,
  input  logic              cmdPending,
  input  logic              cmdFront,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic              allocSecure,
  input  logic [TIME_W-1:0] allocReady,
  input  logic              allocNeedResp,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkSecure,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [IDX_W-1:0]  allocIdx,
  output logic              issueValid,
  output logic [IDX_W-1:0]  issueIdx,
  output logic [ORD_W-1:0]  issueOrder,
  output logic [TIME_W-1:0] nextReady,
  output logic [CNT_W-1:0]  allocCount,
  output logic [CNT_W-1:0]  inServiceCount,
  output logic              isFull,
  output logic              canPrefetch,
  output logic              errFlag
);
  mtqStrobe_t       strb;
  logic [IDX_W-1:0] opIdx;
  logic [NUM-1:0]   validVec, inSvcVec, respVec;
  logic             freeAvail;

  mtq_ctrl #(
    .NUM(NUM), .RESERVE(RESERVE), .DEMAND(DEMAND_RESERVE),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdAlloc(cmdAlloc), .cmdFree(cmdFree), .cmdInSvc(cmdInSvc),
    .cmdPending(cmdPending), .cmdFront(cmdFront), .cmdIdx(cmdIdx),
    .validVec(validVec), .inSvcVec(inSvcVec), .respVec(respVec),
    .freeIdx(allocIdx), .freeAvail(freeAvail),
    .strb(strb), .opIdx(opIdx),
    .allocCnt(allocCount), .svcCnt(inServiceCount),
    .isFull(isFull), .canPrefetch(canPrefetch), .errFlag(errFlag)
  );

  mtq_store #(
    .NUM(NUM), .ADDR_W(ADDR_W), .TIME_W(TIME_W), .ORD_W(ORD_W),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) uStore (
    .clk(clk), .rstN(rstN),
    .strb(strb), .opIdx(opIdx),
    .allocAddr(allocAddr), .allocSecure(allocSecure),
    .allocReady(allocReady), .allocNeedResp(allocNeedResp),
    .curTime(curTime), .lkAddr(lkAddr), .lkSecure(lkSecure),
    .validVec(validVec), .inSvcVec(inSvcVec), .respVec(respVec),
    .freeIdx(allocIdx), .freeAvail(freeAvail),
    .lkHit(lkHit), .lkIdx(lkIdx),
    .issueValid(issueValid), .issueIdx(issueIdx),
    .issueOrder(issueOrder), .nextReady(nextReady)
  );
endmodule

// File: tb/sim_miss_track_queue.sv
`timescale 1ns/1ps
module sim_miss_track_queue;
  localparam int NUM = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] curTime = '0;
  logic        cmdAlloc = 0, cmdFree = 0, cmdInSvc = 0, cmdPending = 0, cmdFront = 0;
  logic [2:0]  cmdIdx = '0;
  logic [15:0] allocAddr = '0, allocReady = '0, lkAddr = '0;
  logic        allocSecure = 0, allocNeedResp = 0, lkSecure = 0;
  logic        lkHit, issueValid, isFull, canPrefetch, errFlag;
  logic [2:0]  lkIdx, allocIdx, issueIdx, allocCount, inServiceCount;
  logic [7:0]  issueOrder;
  logic [15:0] nextReady;

  miss_track_queue u0 (.*);

  always #2.5 clk = ~clk;

  int nChk = 0, nBad = 0;
  bit done = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model
  bit          mV[NUM], mS[NUM], mR[NUM], mSec[NUM];
  int          mAddr[NUM], mRdy[NUM], mOrd[NUM];
  int          mq[$];
  int          mCnt, mSvc, mOrdCtr;
  bit          mErr;

  typedef struct {
    int full, pf, iv, ii, io, nr, cnt, svc, err;
  } exp_t;
  exp_t expQ[$];

  function automatic void mReset();
    for (int i = 0; i < NUM; i++) begin mV[i] = 0; mS[i] = 0; end
    mq.delete(); mCnt = 0; mSvc = 0; mOrdCtr = 0; mErr = 0;
  endfunction

  function automatic void mRemove(int idx);
    for (int k = 0; k < mq.size(); k++)
      if (mq[k] == idx) begin mq.delete(k); break; end
  endfunction

  function automatic int mLowFree();
    for (int i = 0; i < NUM; i++) if (!mV[i]) return i;
    return -1;
  endfunction

  function automatic exp_t mExpect(int t);
    exp_t e;
    e.full = (mCnt > NUM - 2);
    e.pf   = (mCnt < NUM - 3);
    e.iv   = (mq.size() > 0) && (mRdy[mq[0]] <= t);
    e.ii   = e.iv ? mq[0] : 0;
    e.io   = e.iv ? mOrd[mq[0]] : 0;
    e.nr   = (mq.size() > 0) ? mRdy[mq[0]] : 16'hFFFF;
    e.cnt  = mCnt; e.svc = mSvc; e.err = mErr;
    return e;
  endfunction

  // driver: one command, model update, expectation for the next edge
  task automatic drive(bit a, bit f, bit s, bit p, bit fr, int idx,
                       int addr, bit sec, int rdy, bit resp, int t);
    int fi;
    cmdAlloc = a; cmdFree = f; cmdInSvc = s; cmdPending = p; cmdFront = fr;
    cmdIdx = 3'(idx); allocAddr = 16'(addr); allocSecure = sec;
    allocReady = 16'(rdy); allocNeedResp = resp; curTime = 16'(t);
    if (a) begin
      fi = mLowFree();
      if (fi < 0) mErr = 1;
      else begin
        mV[fi] = 1; mS[fi] = 0; mR[fi] = resp; mSec[fi] = sec;
        mAddr[fi] = addr; mRdy[fi] = rdy; mOrd[fi] = mOrdCtr % 256;
        mOrdCtr++; mCnt++; mq.push_back(fi);
      end
    end else if (f) begin
      if (!mV[idx]) mErr = 1;
      else begin
        mRemove(idx);
        if (mS[idx]) mSvc--;
        mV[idx] = 0; mS[idx] = 0; mCnt--;
      end
    end else if (s) begin
      if (mV[idx] && !mS[idx]) begin
        mRemove(idx);
        if (mR[idx]) begin mS[idx] = 1; mSvc++; end
        else begin mV[idx] = 0; mCnt--; end
      end
    end else if (p) begin
      if (mV[idx] && mS[idx]) begin mS[idx] = 0; mSvc--; mq.push_back(idx); end
    end else if (fr) begin
      if (mV[idx] && !mS[idx]) begin mRemove(idx); mq.push_front(idx); end
    end
    expQ.push_back(mExpect(t));
    @(negedge clk);
    cmdAlloc = 0; cmdFree = 0; cmdInSvc = 0; cmdPending = 0; cmdFront = 0;
  endtask

  task automatic idle(int t);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, t);
  endtask

  // monitor: compare each expectation just after the edge it belongs to
  always @(posedge clk) begin
    #1;
    while (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      chk("R2", "isFull", isFull, e.full);
      chk("R3", "canPrefetch", canPrefetch, e.pf);
      chk("R5", "issueValid", issueValid, e.iv);
      if (e.iv) begin
        chk("R5", "issueIdx", issueIdx, e.ii);
        chk("R10", "issueOrder", issueOrder, e.io);
      end
      chk("R6", "nextReady", nextReady, e.nr);
      chk("R7", "allocCount", allocCount, e.cnt);
      chk("R8", "inServiceCount", inServiceCount, e.svc);
      chk("R11", "errFlag", errFlag, e.err);
    end
  end

  // R4: combinational lookup against the model
  task automatic look(int addr, bit sec);
    int ei;
    ei = -1;
    lkAddr = 16'(addr); lkSecure = sec;
    for (int i = NUM - 1; i >= 0; i--)
      if (mV[i] && mAddr[i] == addr && mSec[i] == sec) ei = i;
    #0.5;
    chk("R4", "lkHit", lkHit, ei >= 0);
    if (ei >= 0) chk("R4", "lkIdx", lkIdx, ei);
  endtask

  task automatic doReset();
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    mReset();
    // R13
    chk("R13", "allocCount", allocCount, 0);
    chk("R13", "inServiceCount", inServiceCount, 0);
    chk("R13", "issueValid", issueValid, 0);
    chk("R13", "nextReady", nextReady, 16'hFFFF);
    chk("R13", "errFlag", errFlag, 0);
    chk("R1", "allocIdx", allocIdx, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    doReset();
    // R11: releasing a free entry
    drive(0, 1, 0, 0, 0, 3, 0, 0, 0, 0, 0);
    doReset();
    // R10 allocations, R5 not yet ready
    drive(1, 0, 0, 0, 0, 0, 16'h100, 0, 10, 1, 0);
    chk("R1", "allocIdx", allocIdx, 1);
    drive(1, 0, 0, 0, 0, 0, 16'h100, 1, 5, 1, 0);
    look(16'h100, 1);
    look(16'h100, 0);
    look(16'h200, 0);
    idle(9);
    idle(10);
    // R9 promote entry 1
    drive(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 10);
    // R7 send entry 1
    drive(0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 10);
    // R9 no effect on in-service entry
    drive(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 10);
    // R8 resend
    drive(0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 10);
    // fill the pool: R2, R3
    drive(1, 0, 0, 0, 0, 0, 16'h300, 0, 0, 0, 10);
    drive(1, 0, 0, 0, 0, 0, 16'h400, 1, 3, 1, 10);
    drive(1, 0, 0, 0, 0, 0, 16'h500, 0, 20, 1, 10);
    chk("R1", "allocIdx full pool", allocIdx, 0);
    look(16'h500, 0);
    // R1 / R11 allocation with nothing free
    drive(1, 0, 0, 0, 0, 0, 16'h600, 0, 0, 1, 10);
    look(16'h600, 0);
    doReset();
    drive(1, 0, 0, 0, 0, 0, 16'h10, 0, 2, 1, 0);
    drive(1, 0, 0, 0, 0, 0, 16'h20, 0, 1, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 16'h30, 0, 0, 1, 0);
    idle(2);
    // R10 release entry 0 (head), list shifts
    drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2);
    chk("R1", "allocIdx reuse", allocIdx, 0);
    // R12 allocate and release together: allocate wins
    drive(1, 1, 0, 0, 0, 1, 16'h40, 1, 0, 1, 2);
    look(16'h20, 0);
    look(16'h40, 1);
    // R12 release over in-service
    drive(0, 1, 1, 0, 0, 2, 0, 0, 0, 0, 2);
    // R7 send an entry that expects no reply: released
    drive(0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 2);
    look(16'h20, 0);
    // R9 front of tail entry, then R7 send and release in service
    drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 2);
    drive(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 2);
    drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2);
    idle(2);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: got hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule